// File: doc/BRIEF.md
# Strobe Watchdog with Selectable Timeout

This block supervises a processor through one strobe line. The processor must keep producing high-to-low transitions on `strobe_i`. If a whole timeout period goes by with no such transition, the block raises `expire_o` for one clock cycle. A reset generator elsewhere stretches that pulse into a system reset.

The timeout is set by a 2-bit code. An external decoder derives that code from a three-level select pin, and the code picks one of three periods: short, middle or long. The nominal ratios are 150, 600 and 1200 time units, and each period is given in clock cycles by a parameter. The watchdog counts only while `run_i` is high, meaning the system reset is released. Each release starts a full period. After one expiry the block stays quiet until `run_i` drops and rises again.

The strobe is asynchronous. It passes through a two-flop synchronizer, and falling edges are detected on the synchronized value. A low level that lasts one clock period is enough to be seen.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after its release, `expire_o` is 0. The synchronizer flops reset to 1, so a strobe that is already high at release produces no edge.
- R2: The select code picks the period P: 2'b00 gives TICKS_LOW (150), 2'b01 gives TICKS_FLOAT (600) and 2'b10 gives TICKS_HIGH (1200). Counting the restart edge as edge 1, `expire_o` is 1 right after edge P.
- R3: Take a clock edge k that samples `strobe_i` as 1, followed by edge k+1 that samples it as 0, even for a single cycle. Edge k+3 is then a restart edge, and the timeout starts over from it.
- R4: A rising edge on `strobe_i`, or a constant level of either value, does not restart the timeout.
- R5: Select code 2'b11 gives the same period as 2'b01 (TICKS_FLOAT).
- R6: While `run_i` is low, `expire_o` stays 0 and the elapsed count is held at zero. The first edge that samples `run_i` high is a restart edge.
- R7: `expire_o` is high for exactly one cycle. After that, neither strobes nor elapsed time produce another pulse until `run_i` has been sampled low and then high again.
- R8: The period follows the current value of `sel_i` at every edge. If a change to a shorter period leaves the elapsed count already at or past the new limit, `expire_o` rises right after the next edge.
- R9: A restart edge never produces an expiry, even on the edge where the count would otherwise reach its limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while the system reset is inactive; enables counting |
| strobe_i | input | 1 | Asynchronous processor strobe; its falling edges restart the timeout |
| sel_i | input | 2 | Period select code (00 short, 01 middle, 10 long, 11 middle) |
| expire_o | output | 1 | Single-cycle pulse on timeout |

## Verification
The assertions assume three things about the inputs: `run_i` is synchronous to `clk_i`, `sel_i` is stable enough to be sampled, and every period is at least two cycles. The bench meets all three by driving every input on the falling clock edge, using the default periods, and changing the select only at whole cycles, including during an active count. Strobe activity ranges from long silences to dense toggling. Single-cycle low pulses are included, as are strobes that arrive exactly on the expiry edge and strobes issued after an expiry.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_LOW   = 2'b00,
    SEL_FLOAT = 2'b01,
    SEL_HIGH  = 2'b10,
    SEL_RSVD  = 2'b11
  } wdt_sel_e;
endpackage

// File: rtl/wdt_strobe_edge.sv
module wdt_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= strobe_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int TICKS_LOW   = 150,
  parameter int TICKS_FLOAT = 600,
  parameter int TICKS_HIGH  = 1200,
  parameter int CW          = 11
) (
  input  logic [1:0]    sel_i,
  output logic [CW-1:0] limit_o
);
  // limit is the last elapsed value before expiry
  localparam logic [CW-1:0] LIM_LOW   = CW'(TICKS_LOW - 1);
  localparam logic [CW-1:0] LIM_FLOAT = CW'(TICKS_FLOAT - 1);
  localparam logic [CW-1:0] LIM_HIGH  = CW'(TICKS_HIGH - 1);

  always_comb begin
    unique case (wdt_sel_e'(sel_i))
      SEL_LOW:  limit_o = LIM_LOW;
      SEL_HIGH: limit_o = LIM_HIGH;
      default:  limit_o = LIM_FLOAT;
    endcase
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          expire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      armed_q  <= 1'b1;
      expire_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      armed_q  <= 1'b1;
      expire_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= CW'(1);
      expire_q <= 1'b0;
    end else if (armed_q && cnt_q >= limit_i) begin
      armed_q  <= 1'b0;
      expire_q <= 1'b1;
    end else begin
      expire_q <= 1'b0;
      if (armed_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expire_o = expire_q;
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int TICKS_LOW   = 150,
  parameter int TICKS_FLOAT = 600,
  parameter int TICKS_HIGH  = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       strobe_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  localparam int TICKS_MAX0 = (TICKS_LOW > TICKS_FLOAT) ? TICKS_LOW : TICKS_FLOAT;
  localparam int TICKS_MAX  = (TICKS_HIGH > TICKS_MAX0) ? TICKS_HIGH : TICKS_MAX0;
  localparam int TICKS_MIN0 = (TICKS_LOW < TICKS_FLOAT) ? TICKS_LOW : TICKS_FLOAT;
  localparam int TICKS_MIN  = (TICKS_HIGH < TICKS_MIN0) ? TICKS_HIGH : TICKS_MIN0;
  localparam int CW         = $clog2(TICKS_MAX + 1);

  logic          fall_w;
  logic [CW-1:0] limit_w;

  wdt_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .fall_o  (fall_w)
  );

  wdt_period_sel #(
    .TICKS_LOW  (TICKS_LOW),
    .TICKS_FLOAT(TICKS_FLOAT),
    .TICKS_HIGH (TICKS_HIGH),
    .CW         (CW)
  ) u_sel (
    .sel_i  (sel_i),
    .limit_o(limit_w)
  );

  wdt_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .restart_i(fall_w),
    .limit_i  (limit_w),
    .expire_o (expire_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int TICKS_MIN = 150
) (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic fall_i,
  input logic expire_o
);
  localparam int QW = $clog2(TICKS_MIN + 2) + 1;

  logic [QW-1:0] quiet_q;
  logic          spent_q;

  // cycles since the last restart edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   quiet_q <= '0;
    else if (!run_i)               quiet_q <= '0;
    else if (fall_i)               quiet_q <= QW'(1);
    else if (quiet_q != {QW{1'b1}}) quiet_q <= quiet_q + QW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       spent_q <= 1'b0;
    else if (!run_i)   spent_q <= 1'b0;
    else if (expire_o) spent_q <= 1'b1;
  end

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  a_r7_no_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spent_q |-> !expire_o);
  a_r6_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !expire_o);
  a_r3_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !fall_i);
  a_r9_restart_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && run_i) |=> !expire_o);
  a_r2_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (quiet_q >= QW'(TICKS_MIN)));
endmodule

bind strobe_watchdog wdt_chk #(.TICKS_MIN(TICKS_MIN)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .fall_i  (fall_w),
  .expire_o(expire_o)
);

// File: tb/sim_strobe_watchdog.sv
`timescale 1ns/1ps
module sim_strobe_watchdog;
  localparam int P_LOW = 150, P_FLOAT = 600, P_HIGH = 1200;

  logic clk = 1'b0, rst_ni = 1'b0, run = 1'b0, strb = 1'b1;
  logic [1:0] sel = 2'b00;
  logic expire;

  int n_chk = 0, n_err = 0;
  // bench model state
  logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
  int   m_cnt = 0;
  bit   m_armed = 1'b1, m_exp = 1'b0;

  always #2 clk = ~clk;

  strobe_watchdog u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .strobe_i(strb),
    .sel_i(sel), .expire_o(expire)
  );

  function automatic int period(input logic [1:0] s);
    case (s)
      2'b00:   return P_LOW;
      2'b10:   return P_HIGH;
      default: return P_FLOAT;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s: expire_o=%0b expected %0b at %0t", tag, act, exp_v, $time);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare after it
  task automatic step(input logic r, input logic s, input logic [1:0] sl);
    string tag;
    bit fall;
    @(negedge clk);
    run = r; strb = s; sel = sl;
    @(posedge clk);
    fall = h3 & ~h2;
    if (!r)            tag = "R6";
    else if (fall)     tag = "R3";
    else if (!m_armed) tag = "R7";
    else if (sl == 2'b11) tag = "R5";
    else               tag = "R2";
    if (!r) begin
      m_cnt = 0; m_armed = 1'b1; m_exp = 1'b0;
    end else if (fall) begin
      m_cnt = 1; m_exp = 1'b0;
    end else if (m_armed && m_cnt >= period(sl) - 1) begin
      m_armed = 1'b0; m_exp = 1'b1;
    end else begin
      m_exp = 1'b0;
      if (m_armed) m_cnt++;
    end
    h3 = h2; h2 = h1; h1 = s;
    #1;
    chk(tag, expire, m_exp);
  endtask

  // steps with fixed inputs until expire_o is seen; returns step count
  task automatic until_exp(input logic [1:0] sl, input int lim, output int n);
    n = 0;
    do begin
      step(1'b1, 1'b1, sl);
      n++;
    end while (!expire && n < lim);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b1, sel);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: run hung, expire_o=%0b expected completion", expire);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd7741));
    #1 chk("R1 in reset", expire, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #3 chk("R1 after release", expire, 1'b0);

    // R2/R5: each code, quiet from run rising
    for (int c = 0; c < 4; c++) begin
      idle(3);
      until_exp(2'(c), 3000, n);
      chk(c == 3 ? "R5 period" : "R2 period", 1'(n == period(2'(c))), 1'b1);
      if (n != period(2'(c))) $display("FAIL R2 code %0d: %0d cycles expected %0d", c, n, period(2'(c)));
    end

    // R7: after expiry, strobes and time give nothing until run cycles
    for (int i = 0; i < 400; i++) step(1'b1, 1'(i % 4 != 0), 2'b00);
    idle(2);
    until_exp(2'b00, 3000, n);
    chk("R7 rearm after run low", 1'(n == P_LOW), 1'b1);

    // R3: single-cycle low pulse restarts; expiry P+1 steps after pulse step
    idle(2);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 2'b00);
    step(1'b1, 1'b0, 2'b00);
    until_exp(2'b00, 3000, n);
    chk("R3 single-cycle strobe", 1'(n == P_LOW + 1), 1'b1);

    // R4: strobe low during run low, rising while counting: no restart
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 2'b00);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 2'b00);
    until_exp(2'b00, 3000, n);
    chk("R4 rising edge ignored", 1'(n + 50 == P_LOW), 1'b1);

    // R9: restart edge lands on the limit edge
    idle(2);
    for (int i = 1; i <= P_LOW - 3; i++) step(1'b1, 1'b1, 2'b00);
    step(1'b1, 1'b0, 2'b00);
    step(1'b1, 1'b1, 2'b00);
    step(1'b1, 1'b1, 2'b00);
    chk("R9 restart wins", expire, 1'b0);
    until_exp(2'b00, 3000, n);
    chk("R9 restart wins period", 1'(n == P_LOW - 1), 1'b1);

    // R8: switch long to short after the short limit has passed
    idle(2);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 2'b10);
    chk("R8 no expiry on long", expire, 1'b0);
    step(1'b1, 1'b1, 2'b00);
    chk("R8 immediate on shorter", expire, 1'b1);

    // random segments; the per-step model checks every cycle
    for (int seg = 0; seg < 40; seg++) begin
      logic [1:0] sl;
      int len, div;
      sl  = 2'($urandom % 4);
      len = 50 + int'($urandom % (3 * period(sl)));
      case ($urandom % 3)
        0:       div = 1 << 30;
        1:       div = period(sl) / 3;
        default: div = 3;
      endcase
      idle(1 + int'($urandom % 3));
      for (int i = 0; i < len; i++) begin
        if ($urandom % 500 == 0) sl = 2'($urandom % 4);
        step(1'b1, 1'(($urandom % div) != 0), sl);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule